// File: doc/BRIEF.md
# Parallel-to-Serial Word Serializer

The block takes a parallel word and streams it out on a single-bit line, one bit per rising clock edge, most significant bit first. A load strobe captures the whole word in one edge. A separate send enable then advances the stream by one bit on each edge where it is high. Zeros fill in behind the word, so a line kept in send after the last bit carries only zeros. A done flag tells the consumer that the final bit is on the line.

The datapath has two variants, picked by a parameter. One keeps the word in a shift register and drives its top bit out. The other keeps the word still and uses a down-counting index into a word-wide multiplexer. Both produce the same serial stream and done flag, cycle for cycle. A consumer rebuilds words with a serial-in parallel-out register that samples the line one cycle after each send.

Top module: `wordSerializer`

## Requirements
- R1: A synchronous active-high reset drives serialOut and doneOut to 0 and empties the held word. Send cycles after a reset and before any load put 0 on serialOut.
- R2: With loadIn high at a rising edge, all WORD_W bits of dataIn are captured at once, and serialOut keeps its previous value on that edge. A load in the middle of a word restarts the stream at bit WORD_W-1 of the new word.
- R3: When loadIn and sendIn are both high on the same edge, the load wins. The word is captured, no bit is sent, and serialOut is unchanged.
- R4: On each edge with sendIn high and loadIn low, serialOut takes the next bit of the held word. The order is bit WORD_W-1 (bit 11 at the default width) down to bit 0, one bit per edge, so a whole word needs exactly WORD_W send edges after its load.
- R5: On an edge with both loadIn and sendIn low, serialOut, doneOut and the stream position stay as they are. A later send continues with the next unsent bit.
- R6: A send edge after all WORD_W bits have gone out puts 0 on serialOut.
- R7: doneOut is 0 after a load and rises on the edge that puts bit 0 on serialOut. It stays 1 until the next load or reset.
- R8: The shift-register variant (USE_MUX=0) and the indexed-multiplexer variant (USE_MUX=1) give identical serialOut and doneOut on every cycle for any input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| loadIn | input | 1 | Capture dataIn into the held word; wins over sendIn |
| sendIn | input | 1 | Shift one bit onto serialOut this edge |
| dataIn | input | WORD_W | Parallel word to transmit |
| serialOut | output | 1 | Serial bit stream, MSB first, zero-filled |
| doneOut | output | 1 | High once bit 0 of the current word is on serialOut |

## Verification
A wrong held word or stream position shows on serialOut at the first send edge where the bad bit would be driven. At worst that is WORD_W edges after the load, which is when the rebuilt word fails to match. A wrong remaining-bit count shows on doneOut, either one edge early or late at the end of a word, or as a nonzero bit after the word is finished. Running both variants side by side catches a difference between them on the cycle it first appears, not at the end of the word.

// File: rtl/serializer_pkg.sv
package serializer_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic capture;   // take a new word from dataIn
    logic advance;   // put the next bit on the line
  } serStrobes_t;

  function automatic int cntWidth(input int wordW);
    return $clog2(wordW + 1);
  endfunction

  function automatic int idxWidth(input int wordW);
    return (wordW > 1) ? $clog2(wordW) : 1;
  endfunction

endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import serializer_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        loadIn,
  input  logic        sendIn,
  output serStrobes_t strobes,
  output logic        doneOut
);

  localparam int CNT_W = cntWidth(WORD_W);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0] bitsLeft;
  logic             doneReg;

  // Load has priority: a send in the same cycle is dropped
  always_comb begin
    strobes.capture = loadIn;
    strobes.advance = sendIn && !loadIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitsLeft <= '0;
      doneReg  <= 1'b0;
    end else if (strobes.capture) begin
      bitsLeft <= FULL;
      doneReg  <= 1'b0;
    end else if (strobes.advance && bitsLeft != '0) begin
      bitsLeft <= bitsLeft - 1'b1;
      if (bitsLeft == CNT_W'(1)) doneReg <= 1'b1;
    end
  end

  assign doneOut = doneReg;

endmodule

// File: rtl/ser_data.sv
module ser_data
  import serializer_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter bit USE_MUX = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  serStrobes_t       strobes,
  input  logic [WORD_W-1:0] dataIn,
  output logic              serialOut
);

  localparam int IDX_W = idxWidth(WORD_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] wordReg;
  logic              outReg;

  generate
    if (USE_MUX) begin : g_mux
      // Word stays put; a down-counting index picks the bit
      logic [IDX_W-1:0] bitIdx;
      logic             live;

      always_ff @(posedge clk) begin
        if (rst) begin
          wordReg <= '0;
          bitIdx  <= '0;
          live    <= 1'b0;
          outReg  <= 1'b0;
        end else if (strobes.capture) begin
          wordReg <= dataIn;
          bitIdx  <= TOP_IDX;
          live    <= 1'b1;
        end else if (strobes.advance) begin
          outReg <= live ? wordReg[bitIdx] : 1'b0;
          if (live) begin
            if (bitIdx == '0) live <= 1'b0;
            else              bitIdx <= bitIdx - 1'b1;
          end
        end
      end
    end else begin : g_shift
      // Word moves up one place per send; zero enters at the bottom
      always_ff @(posedge clk) begin
        if (rst) begin
          wordReg <= '0;
          outReg  <= 1'b0;
        end else if (strobes.capture) begin
          wordReg <= dataIn;
        end else if (strobes.advance) begin
          outReg  <= wordReg[WORD_W-1];
          wordReg <= {wordReg[WORD_W-2:0], 1'b0};
        end
      end
    end
  endgenerate

  assign serialOut = outReg;

endmodule

// File: rtl/wordSerializer.sv
module wordSerializer
  import serializer_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter bit USE_MUX = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadIn,
  input  logic              sendIn,
  input  logic [WORD_W-1:0] dataIn,
  output logic              serialOut,
  output logic              doneOut
);

  serStrobes_t strobes;

  ser_ctrl #(.WORD_W(WORD_W)) ctrl (
    .clk     (clk),
    .rst     (rst),
    .loadIn  (loadIn),
    .sendIn  (sendIn),
    .strobes (strobes),
    .doneOut (doneOut)
  );

  ser_data #(.WORD_W(WORD_W), .USE_MUX(USE_MUX)) data (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .dataIn    (dataIn),
    .serialOut (serialOut)
  );

endmodule

// File: rtl/serializerChecker.sv
module serializerChecker (
  input logic clk,
  input logic rst,
  input logic loadIn,
  input logic sendIn,
  input logic serialOut,
  input logic doneOut
);

  logic seenLoad;

  always_ff @(posedge clk) begin
    if (rst)         seenLoad <= 1'b0;
    else if (loadIn) seenLoad <= 1'b1;
  end

  // R1: no word loaded since reset means the line stays at zero
  a_r1_zero_before_load: assert property (@(posedge clk) disable iff (rst)
    !seenLoad |-> serialOut == 1'b0);

  // R2 / R3: an edge with load leaves the line as it was
  a_r3_load_keeps_line: assert property (@(posedge clk) disable iff (rst)
    loadIn |=> $stable(serialOut));

  // R5: idle edges change nothing visible
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!loadIn && !sendIn) |=> ($stable(serialOut) && $stable(doneOut)));

  // R6: once the word is out, further sends drive zero
  a_r6_zero_after_word: assert property (@(posedge clk) disable iff (rst)
    (doneOut && sendIn && !loadIn) |=> serialOut == 1'b0);

  // R7: a load clears done
  a_r7_done_cleared_by_load: assert property (@(posedge clk) disable iff (rst)
    loadIn |=> !doneOut);

  // R7: done never falls without a load
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (doneOut && !loadIn) |=> doneOut);

endmodule

bind wordSerializer serializerChecker chk (
  .clk       (clk),
  .rst       (rst),
  .loadIn    (loadIn),
  .sendIn    (sendIn),
  .serialOut (serialOut),
  .doneOut   (doneOut)
);

// File: tb/wordSerializer_test.sv
module serialCollector #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sendSeen,
  input  logic              bitIn,
  output logic [WORD_W-1:0] wordOut
);
  logic shiftNext;
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftNext <= 1'b0;
      wordOut   <= '0;
    end else begin
      shiftNext <= sendSeen;
      if (shiftNext) wordOut <= {wordOut[WORD_W-2:0], bitIn};
    end
  end
endmodule

module wordSerializer_test;
  localparam int WORD_W = 12;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 8;
  // entry = {pauseAfterBit[3:0], word[11:0]}; pause 4'hF means none
  localparam logic [15:0] VECS [NVEC] = '{
    {4'hF, 12'hFFF}, {4'h3, 12'h000}, {4'hB, 12'h800}, {4'h0, 12'h001},
    {4'h6, 12'hA5A}, {4'hF, 12'h5A5}, {4'h9, 12'h7E1}, {4'hF, 12'hC33}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadIn = 1'b0;
  logic sendIn = 1'b0;
  logic [WORD_W-1:0] dataIn = '0;
  logic serialOut, doneOut, serialMux, doneMux;
  logic [WORD_W-1:0] rxWord;

  int checks = 0;
  int fails = 0;
  int schemeMiss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wordSerializer #(.WORD_W(WORD_W), .USE_MUX(1'b0)) uut (
    .clk(clk), .rst(rst), .loadIn(loadIn), .sendIn(sendIn),
    .dataIn(dataIn), .serialOut(serialOut), .doneOut(doneOut));

  wordSerializer #(.WORD_W(WORD_W), .USE_MUX(1'b1)) uutMux (
    .clk(clk), .rst(rst), .loadIn(loadIn), .sendIn(sendIn),
    .dataIn(dataIn), .serialOut(serialMux), .doneOut(doneMux));

  serialCollector #(.WORD_W(WORD_W)) rx (
    .clk(clk), .rst(rst), .sendSeen(sendIn && !loadIn),
    .bitIn(serialOut), .wordOut(rxWord));

  // R8: both variants compared on every cycle
  always @(negedge clk) begin
    if (serialOut !== serialMux || doneOut !== doneMux) schemeMiss++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, back to negedge to sample
  task automatic step(input logic ld, input logic sd, input logic [WORD_W-1:0] d);
    loadIn = ld; sendIn = sd; dataIn = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [WORD_W-1:0] w, input logic [3:0] pauseAt, input string tag);
    bit bitsOk = 1;
    bit doneOk = 1;
    bit held;
    step(1'b1, 1'b0, w);
    check(doneOut == 1'b0, "R7 done low after load", doneOut, 0);
    for (int b = WORD_W - 1; b >= 0; b--) begin
      step(1'b0, 1'b1, '0);
      if (serialOut !== w[b]) bitsOk = 0;
      if (doneOut !== (b == 0)) doneOk = 0;
      if (pauseAt == 4'(b)) begin
        held = serialOut;
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        check(serialOut == held && doneOut == (b == 0), "R5 pause holds line", serialOut, held);
      end
    end
    check(bitsOk, {"R4 bit order ", tag}, bitsOk, 1);
    check(doneOk, {"R7 done timing ", tag}, doneOk, 1);
    step(1'b0, 1'b0, '0);
    check(rxWord == w, {"R4 rebuilt word ", tag}, rxWord, w);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic held;
    @(negedge clk);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    check(serialOut == 0 && doneOut == 0, "R1 reset state", {serialOut, doneOut}, 0);
    rst = 1'b0;
    // R1: sending with nothing loaded gives zeros
    begin
      bit zOk = 1;
      for (int i = 0; i < 3; i++) begin
        step(1'b0, 1'b1, 12'hFFF);
        if (serialOut !== 1'b0) zOk = 0;
      end
      check(zOk, "R1 zeros before load", zOk, 1);
    end

    for (int v = 0; v < NVEC; v++) begin
      sendWord(VECS[v][11:0], VECS[v][15:12], $sformatf("vec%0d", v));
    end

    // R6: sends past the end are zero, done stays (R7)
    begin
      bit zOk = 1;
      for (int i = 0; i < 4; i++) begin
        step(1'b0, 1'b1, '0);
        if (serialOut !== 1'b0 || doneOut !== 1'b1) zOk = 0;
      end
      check(zOk, "R6 zeros after word, R7 done held", zOk, 1);
    end

    // R2: load keeps the line value; mid-word reload restarts at bit 11
    step(1'b1, 1'b0, 12'hFFF);
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    held = serialOut;
    step(1'b1, 1'b0, 12'h400);
    check(serialOut == held, "R2 line unchanged on load", serialOut, held);
    step(1'b0, 1'b1, '0);
    check(serialOut == 1'b0, "R2 reload starts at bit 11", serialOut, 0);
    step(1'b0, 1'b1, '0);
    check(serialOut == 1'b1, "R2 reload bit 10", serialOut, 1);

    // R3: load and send together -> load wins
    step(1'b1, 1'b0, 12'hA5C);
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    held = serialOut;
    step(1'b1, 1'b1, 12'h3F1);
    check(serialOut == held && doneOut == 0, "R3 load beats send", serialOut, held);
    begin
      bit bOk = 1;
      logic [WORD_W-1:0] w = 12'h3F1;
      for (int b = WORD_W - 1; b >= 0; b--) begin
        step(1'b0, 1'b1, '0);
        if (serialOut !== w[b]) bOk = 0;
      end
      check(bOk, "R3 full word after contested load", bOk, 1);
      check(doneOut == 1'b1, "R7 done after contested word", doneOut, 1);
    end

    // R1: reset mid-word
    step(1'b1, 1'b0, 12'hFFF);
    step(1'b0, 1'b1, '0);
    rst = 1'b1;
    step(1'b0, 1'b1, '0);
    rst = 1'b0;
    check(serialOut == 0 && doneOut == 0, "R1 mid-word reset", {serialOut, doneOut}, 0);
    step(1'b0, 1'b1, '0);
    check(serialOut == 1'b0, "R1 word discarded by reset", serialOut, 0);

    check(schemeMiss == 0, "R8 variants match", schemeMiss, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule